// File: doc/BRIEF.md
# Telephony Bus Clock Output Generator

This block runs from a 16.384 MHz master clock and derives every clock and frame signal that a telephony backplane node drives. A free-running 11-bit position counter covers one 125 µs frame, which is 2048 master cycles. The counter's low bits give 8.192, 4.096 and 2.048 MHz clocks. Decodes around the counter wrap give an 8 kHz bus frame strobe and a compatibility frame pulse.

A single 8-bit control byte sets up all outputs:

- the bus clock rate and polarity;
- the width of the compatibility frame pulse;
- separate enables for two redundant clock/frame output pairs;
- a framer clock selector that picks among eight sources;
- a mode bit that tells receive logic elsewhere how to read incoming bus clocks.

The oscillator clock and the two PLL clocks enter as ports and are only selected here. Each output pair also has a clock-failure flag input that shuts that pair off at once. Control writes are held in a pending copy and become active only at the frame boundary, so the outputs never glitch in the middle of a frame.

Top module: `tbus_clkgen`

## Requirements
- R1: Bits 7..5 of the active byte choose the framer clock: 000 disabled (`fr_clk_oe` low, `fr_clk` low), 001 `osc_clk`, 010 `pll2_clk`, 011 `pll2_half_clk`, 100 the 2.048 MHz divided clock (position bit 2), 101 the 4.096 MHz clock (position bit 1), 110 the 8.192 MHz clock (position bit 0), 111 the master clock itself. Every code other than 000 drives `fr_clk_oe` high.
- R2: When active bit 1 is 1, the internal bus clock equals position bit 0 (true 8.192 MHz). When bit 1 is 0, it equals the inverse of position bit 1 (inverted 4.096 MHz).
- R3: `comp_frame_n` is low at positions 2047 and 0 when active bit 0 is 0. It is low at positions 2046, 2047, 0 and 1 when bit 0 is 1. It is high at all other positions.
- R4: The internal bus frame strobe is low at positions 2047 and 0 and high elsewhere, so it repeats every 2048 master cycles.
- R5: Active bit 3 enables pair A and bit 2 enables pair B. A pair that is not enabled drives its output enable low, its clock low and its frame high.
- R6: While `fail_a` (or `fail_b`) is high, pair A (or pair B) is disabled in that same cycle, whatever its enable bit says.
- R7: An enabled pair carries the internal bus clock and bus frame strobe, so two enabled pairs are always identical.
- R8: `rx_c8_mode` equals active bit 4: 1 means 8 MHz clock with frame, and 0 means inverted 4 MHz clock with frame.
- R9: A byte written with `cfg_wr` becomes pending. The active byte takes the pending value at the clock edge where the position is 2047. A write sampled at that same edge only reaches the active byte at the next boundary. When several writes occur within one frame, the last one wins.
- R10: Reset clears the position, the pending byte and the active byte to zero. The position is 0 during reset and advances by one, modulo 2048, on every master clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte value |
| osc_clk | input | 1 | Oscillator clock source |
| pll2_clk | input | 1 | Second PLL output, direct |
| pll2_half_clk | input | 1 | Second PLL output divided by two |
| fail_a | input | 1 | Clock failure flag for pair A |
| fail_b | input | 1 | Clock failure flag for pair B |
| bus_clk_a | output | 1 | Pair A bus clock |
| bus_frame_n_a | output | 1 | Pair A frame strobe, active low |
| bus_oe_a | output | 1 | Pair A output enable |
| bus_clk_b | output | 1 | Pair B bus clock |
| bus_frame_n_b | output | 1 | Pair B frame strobe, active low |
| bus_oe_b | output | 1 | Pair B output enable |
| comp_frame_n | output | 1 | Compatibility frame pulse, active low |
| fr_clk | output | 1 | Selected framer clock |
| fr_clk_oe | output | 1 | Framer clock output enable |
| rx_c8_mode | output | 1 | Receive-side bus clock interpretation |

## Verification
Counter-derived outputs change on the same edge that advances the position, so they are due one edge after the position they encode. A control write only shows at the outputs on the edge after the position-2047 edge that follows it. Failure flags and the externally supplied source clocks reach the pins without passing through a register, in the same cycle. The bench keeps a behavioural position and pending/active byte model that it advances at each rising edge. It compares every output 1.25 ns after that edge, when the master clock is high and no bench-driven source clock is switching, so each result is read in the cycle it is due.

// File: rtl/tbus_pkg.sv
`timescale 1ns/1ps
package tbus_pkg;

    // Framer clock source codes; the numbering is the programming interface.
    typedef enum logic [2:0] {
        FCK_OFF      = 3'b000,
        FCK_OSC      = 3'b001,
        FCK_PLL      = 3'b010,
        FCK_PLL_HALF = 3'b011,
        FCK_DIV2M    = 3'b100,
        FCK_DIV4M    = 3'b101,
        FCK_DIV8M    = 3'b110,
        FCK_MASTER   = 3'b111
    } fclk_sel_e;

    // Control byte, most significant field first.
    typedef struct packed {
        fclk_sel_e fclk_sel;   // bits 7..5
        logic      rx_c8;      // bit 4
        logic      en_a;       // bit 3
        logic      en_b;       // bit 2
        logic      bus_fast;   // bit 1
        logic      frame_wide; // bit 0
    } tbus_cfg_t;

    // Divided clocks taken from the position counter.
    typedef struct packed {
        logic d8m;
        logic d4m;
        logic d2m;
    } div_clks_t;

    // Internal clock/frame pair shared by all output pairs.
    typedef struct packed {
        logic clk;
        logic frame_n;
    } bus_sig_t;

    // Pin-level view of one output pair.
    typedef struct packed {
        logic clk;
        logic frame_n;
        logic oe;
    } pair_pins_t;

    // True when pos lies in the window that straddles the counter wrap:
    // [lo_edge, end of frame) or [0, hi_edge).
    function automatic logic near_wrap(logic [15:0] pos,
                                       logic [15:0] lo_edge,
                                       logic [15:0] hi_edge);
        return (pos >= lo_edge) || (pos < hi_edge);
    endfunction

    // Internal bus clock form chosen by the rate bit.
    function automatic logic bus_clock_form(logic fast, div_clks_t d);
        return fast ? d.d8m : ~d.d4m;
    endfunction

endpackage

// File: rtl/tbus_cfg_reg.sv
`timescale 1ns/1ps
module tbus_cfg_reg
    import tbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       boundary,
    output tbus_cfg_t  cfg_act
);

    logic [7:0] pend_q;
    logic [7:0] act_q;

    // Writes land in the pending copy; the active copy follows only at the
    // last cycle of a frame, so the outputs switch on the frame wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr_en) begin
                pend_q <= wr_data;
            end
            if (boundary) begin
                act_q <= pend_q;
            end
        end
    end

    assign cfg_act = tbus_cfg_t'(act_q);

endmodule

// File: rtl/tbus_timebase.sv
`timescale 1ns/1ps
module tbus_timebase
    import tbus_pkg::*;
#(
    parameter int unsigned CNT_W      = 11,
    parameter int unsigned BUS_FR_CYC = 2,
    parameter int unsigned NARROW_CYC = 2,
    parameter int unsigned WIDE_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_wide,
    output logic [CNT_W-1:0] pos,
    output logic             boundary,
    output div_clks_t        div,
    output logic             bus_frame_n,
    output logic             comp_frame_n
);

    localparam int unsigned     PERIOD  = 1 << CNT_W;
    localparam logic [CNT_W-1:0] POS_MAX = '1;
    localparam logic [15:0] BUS_LO    = 16'(PERIOD - BUS_FR_CYC / 2);
    localparam logic [15:0] BUS_HI    = 16'(BUS_FR_CYC / 2);
    localparam logic [15:0] NARROW_LO = 16'(PERIOD - NARROW_CYC / 2);
    localparam logic [15:0] NARROW_HI = 16'(NARROW_CYC / 2);
    localparam logic [15:0] WIDE_LO   = 16'(PERIOD - WIDE_CYC / 2);
    localparam logic [15:0] WIDE_HI   = 16'(WIDE_CYC / 2);

    logic [CNT_W-1:0] pos_q;
    logic [15:0]      pos_ext;

    // One free-running counter spans the whole frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign pos      = pos_q;
    assign pos_ext  = 16'(pos_q);
    assign boundary = (pos_q == POS_MAX);

    // Binary weights of the counter are the divided clocks.
    assign div.d8m = pos_q[0];
    assign div.d4m = pos_q[1];
    assign div.d2m = pos_q[2];

    // Frame pulses sit symmetrically around the wrap.
    assign bus_frame_n = ~near_wrap(pos_ext, BUS_LO, BUS_HI);

    always_comb begin
        if (frame_wide) begin
            comp_frame_n = ~near_wrap(pos_ext, WIDE_LO, WIDE_HI);
        end else begin
            comp_frame_n = ~near_wrap(pos_ext, NARROW_LO, NARROW_HI);
        end
    end

endmodule

// File: rtl/tbus_out_pair.sv
`timescale 1ns/1ps
module tbus_out_pair
    import tbus_pkg::*;
(
    input  logic       en,
    input  logic       fail,
    input  bus_sig_t   bus,
    output pair_pins_t pins
);

    // A failure flag overrides the enable immediately; an idle pair parks
    // its clock low and its frame inactive high.
    always_comb begin
        pins.oe      = en & ~fail;
        pins.clk     = pins.oe & bus.clk;
        pins.frame_n = ~pins.oe | bus.frame_n;
    end

endmodule

// File: rtl/tbus_fclk_mux.sv
`timescale 1ns/1ps
module tbus_fclk_mux
    import tbus_pkg::*;
(
    input  fclk_sel_e sel,
    input  logic      master_clk,
    input  logic      osc_clk,
    input  logic      pll_clk,
    input  logic      pll_half_clk,
    input  div_clks_t div,
    output logic      fr_clk,
    output logic      fr_oe
);

    always_comb begin
        fr_oe = 1'b1;
        unique case (sel)
            FCK_OSC:      fr_clk = osc_clk;
            FCK_PLL:      fr_clk = pll_clk;
            FCK_PLL_HALF: fr_clk = pll_half_clk;
            FCK_DIV2M:    fr_clk = div.d2m;
            FCK_DIV4M:    fr_clk = div.d4m;
            FCK_DIV8M:    fr_clk = div.d8m;
            FCK_MASTER:   fr_clk = master_clk;
            default: begin
                fr_clk = 1'b0;
                fr_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tbus_clkgen.sv
`timescale 1ns/1ps
module tbus_clkgen
    import tbus_pkg::*;
#(
    parameter int unsigned CNT_W      = 11,
    parameter int unsigned BUS_FR_CYC = 2,
    parameter int unsigned NARROW_CYC = 2,
    parameter int unsigned WIDE_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic       osc_clk,
    input  logic       pll2_clk,
    input  logic       pll2_half_clk,
    input  logic       fail_a,
    input  logic       fail_b,
    output logic       bus_clk_a,
    output logic       bus_frame_n_a,
    output logic       bus_oe_a,
    output logic       bus_clk_b,
    output logic       bus_frame_n_b,
    output logic       bus_oe_b,
    output logic       comp_frame_n,
    output logic       fr_clk,
    output logic       fr_clk_oe,
    output logic       rx_c8_mode
);

    localparam int unsigned NUM_PAIRS = 2;

    tbus_cfg_t        cfg_act;
    logic [7:0]       cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             boundary;
    div_clks_t        div;
    bus_sig_t         bus_int;
    logic             bus_frame_n;
    logic [NUM_PAIRS-1:0] pair_en;
    logic [NUM_PAIRS-1:0] pair_fail;
    pair_pins_t           pair_pins [NUM_PAIRS];

    tbus_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_data  (cfg_wdata),
        .boundary (boundary),
        .cfg_act  (cfg_act)
    );

    assign cfg_q = cfg_act;

    tbus_timebase #(
        .CNT_W      (CNT_W),
        .BUS_FR_CYC (BUS_FR_CYC),
        .NARROW_CYC (NARROW_CYC),
        .WIDE_CYC   (WIDE_CYC)
    ) u_tb (
        .clk          (clk),
        .rst          (rst),
        .frame_wide   (cfg_act.frame_wide),
        .pos          (cnt_q),
        .boundary     (boundary),
        .div          (div),
        .bus_frame_n  (bus_frame_n),
        .comp_frame_n (comp_frame_n)
    );

    // One internal clock/frame pair feeds every output pair.
    assign bus_int.clk     = bus_clock_form(cfg_act.bus_fast, div);
    assign bus_int.frame_n = bus_frame_n;

    // Index 0 is pair A, index 1 is pair B.
    assign pair_en   = {cfg_act.en_b, cfg_act.en_a};
    assign pair_fail = {fail_b, fail_a};

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        tbus_out_pair u_pair (
            .en   (pair_en[p]),
            .fail (pair_fail[p]),
            .bus  (bus_int),
            .pins (pair_pins[p])
        );
    end

    assign bus_clk_a     = pair_pins[0].clk;
    assign bus_frame_n_a = pair_pins[0].frame_n;
    assign bus_oe_a      = pair_pins[0].oe;
    assign bus_clk_b     = pair_pins[1].clk;
    assign bus_frame_n_b = pair_pins[1].frame_n;
    assign bus_oe_b      = pair_pins[1].oe;

    tbus_fclk_mux u_fmux (
        .sel          (cfg_act.fclk_sel),
        .master_clk   (clk),
        .osc_clk      (osc_clk),
        .pll_clk      (pll2_clk),
        .pll_half_clk (pll2_half_clk),
        .div          (div),
        .fr_clk       (fr_clk),
        .fr_oe        (fr_clk_oe)
    );

    assign rx_c8_mode = cfg_act.rx_c8;

endmodule

// File: rtl/tbus_clkgen_chk.sv
`timescale 1ns/1ps
module tbus_clkgen_chk #(
    parameter int unsigned CNT_W      = 11,
    parameter int unsigned NARROW_CYC = 2,
    parameter int unsigned WIDE_CYC   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_q,
    input logic [7:0]       cfg_q,
    input logic             fail_a,
    input logic             fail_b,
    input logic             bus_clk_a,
    input logic             bus_frame_n_a,
    input logic             bus_oe_a,
    input logic             bus_clk_b,
    input logic             bus_frame_n_b,
    input logic             bus_oe_b,
    input logic             comp_frame_n,
    input logic             fr_clk,
    input logic             fr_clk_oe
);

    localparam int unsigned      PERIOD      = 1 << CNT_W;
    localparam logic [CNT_W-1:0] POS_MAX     = '1;
    localparam logic [CNT_W-1:0] NARROW_FALL = CNT_W'(PERIOD - NARROW_CYC / 2);
    localparam logic [CNT_W-1:0] WIDE_FALL   = CNT_W'(PERIOD - WIDE_CYC / 2);

    assert_fr_off_R1: assert property (@(posedge clk) disable iff (rst)
        !fr_clk_oe |-> !fr_clk);

    assert_fast_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_oe_a && $past(bus_oe_a) && cfg_q[1] && $past(cfg_q[1]))
            |-> (bus_clk_a != $past(bus_clk_a)));

    assert_comp_fall_pos_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(comp_frame_n) |-> (cnt_q == (cfg_q[0] ? WIDE_FALL : NARROW_FALL)));

    assert_idle_pair_a_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_a |-> (!bus_clk_a && bus_frame_n_a));

    assert_idle_pair_b_R5: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_b |-> (!bus_clk_b && bus_frame_n_b));

    assert_fail_a_R6: assert property (@(posedge clk) disable iff (rst)
        fail_a |-> !bus_oe_a);

    assert_fail_b_R6: assert property (@(posedge clk) disable iff (rst)
        fail_b |-> !bus_oe_b);

    assert_pairs_equal_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_oe_a && bus_oe_b)
            |-> (bus_clk_a == bus_clk_b && bus_frame_n_a == bus_frame_n_b));

    assert_cfg_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> ($past(cnt_q) == POS_MAX));

endmodule

bind tbus_clkgen tbus_clkgen_chk #(
    .CNT_W      (CNT_W),
    .NARROW_CYC (NARROW_CYC),
    .WIDE_CYC   (WIDE_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cnt_q         (cnt_q),
    .cfg_q         (cfg_q),
    .fail_a        (fail_a),
    .fail_b        (fail_b),
    .bus_clk_a     (bus_clk_a),
    .bus_frame_n_a (bus_frame_n_a),
    .bus_oe_a      (bus_oe_a),
    .bus_clk_b     (bus_clk_b),
    .bus_frame_n_b (bus_frame_n_b),
    .bus_oe_b      (bus_oe_b),
    .comp_frame_n  (comp_frame_n),
    .fr_clk        (fr_clk),
    .fr_clk_oe     (fr_clk_oe)
);

// File: tb/tbus_clkgen_bench.sv
`timescale 1ns/1ps
module tbus_clkgen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       osc_clk = 1'b0;
    logic       pll2_clk = 1'b0;
    logic       pll2_half_clk = 1'b0;
    logic       fail_a = 1'b0;
    logic       fail_b = 1'b0;
    logic       bus_clk_a, bus_frame_n_a, bus_oe_a;
    logic       bus_clk_b, bus_frame_n_b, bus_oe_b;
    logic       comp_frame_n, fr_clk, fr_clk_oe, rx_c8_mode;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cycle = 0;
    bit   done = 0;

    // Behavioural reference state.
    int         m_pos = 0;
    logic [7:0] m_pend = 8'h00;
    logic [7:0] m_act = 8'h00;

    tbus_clkgen u_tbus_clkgen (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .osc_clk       (osc_clk),
        .pll2_clk      (pll2_clk),
        .pll2_half_clk (pll2_half_clk),
        .fail_a        (fail_a),
        .fail_b        (fail_b),
        .bus_clk_a     (bus_clk_a),
        .bus_frame_n_a (bus_frame_n_a),
        .bus_oe_a      (bus_oe_a),
        .bus_clk_b     (bus_clk_b),
        .bus_frame_n_b (bus_frame_n_b),
        .bus_oe_b      (bus_oe_b),
        .comp_frame_n  (comp_frame_n),
        .fr_clk        (fr_clk),
        .fr_clk_oe     (fr_clk_oe),
        .rx_c8_mode    (rx_c8_mode)
    );

    always #2.5 clk = ~clk;
    always #7  osc_clk = ~osc_clk;
    always #11 pll2_clk = ~pll2_clk;
    always #13 pll2_half_clk = ~pll2_half_clk;

    task automatic check_bit(input string req, input string what,
                             input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s cycle %0d pos %0d: got %b expected %b",
                     req, what, cycle, m_pos, got, exp);
        end
    endtask

    // Advance the model at each edge, compare 1.25 ns later.
    always begin
        logic fn_bus, comp_exp, bclk, oe_a_exp, oe_b_exp, fr_exp;
        @(posedge clk);
        cycle++;
        if (rst) begin
            m_pos  = 0;   // R10
            m_pend = 8'h00;
            m_act  = 8'h00;
        end else begin
            if (m_pos == 2047) m_act = m_pend;   // R9
            if (cfg_wr) m_pend = cfg_wdata;
            m_pos = (m_pos + 1) % 2048;
        end
        #1.25;
        fn_bus = !(m_pos == 2047 || m_pos == 0);
        comp_exp = m_act[0] ? !(m_pos >= 2046 || m_pos <= 1) : fn_bus;
        bclk = m_act[1] ? m_pos[0] : !m_pos[1];
        oe_a_exp = m_act[3] && !fail_a;
        oe_b_exp = m_act[2] && !fail_b;
        case (m_act[7:5])
            3'd1: fr_exp = osc_clk;
            3'd2: fr_exp = pll2_clk;
            3'd3: fr_exp = pll2_half_clk;
            3'd4: fr_exp = m_pos[2];
            3'd5: fr_exp = m_pos[1];
            3'd6: fr_exp = m_pos[0];
            3'd7: fr_exp = 1'b1;          // master clock is high here
            default: fr_exp = 1'b0;
        endcase
        check_bit("R1", "fr_clk_oe", fr_clk_oe, m_act[7:5] != 3'd0);
        check_bit("R1", "fr_clk", fr_clk, fr_exp);
        check_bit("R3", "comp_frame_n", comp_frame_n, comp_exp);
        check_bit("R5_R6", "bus_oe_a", bus_oe_a, oe_a_exp);
        check_bit("R5_R6", "bus_oe_b", bus_oe_b, oe_b_exp);
        check_bit("R2_R7", "bus_clk_a", bus_clk_a, oe_a_exp & bclk);
        check_bit("R2_R7", "bus_clk_b", bus_clk_b, oe_b_exp & bclk);
        check_bit("R4_R7", "bus_frame_n_a", bus_frame_n_a, !oe_a_exp | fn_bus);
        check_bit("R4_R7", "bus_frame_n_b", bus_frame_n_b, !oe_b_exp | fn_bus);
        check_bit("R8", "rx_c8_mode", rx_c8_mode, m_act[4]);
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for the negedge at which the position equals p.
    task automatic wait_pos(input int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    task automatic write_at_pos(input int p, input logic [7:0] v);
        wait_pos(p);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        idle(4);
        rst = 1'b0;                       // R10: reset state compared above
        idle(300);
        write_cfg(8'h2A);                 // osc, pair A, 8 MHz, narrow
        idle(2200);
        write_cfg(8'h5D);                 // PLL, rx 8M, both pairs, 4M inv, wide
        idle(2200);
        fail_a = 1'b1;  idle(400);        // R6
        fail_a = 1'b0;  fail_b = 1'b1;  idle(400);
        fail_b = 1'b0;
        write_cfg(8'h11);                 // overwritten before boundary (R9)
        write_cfg(8'h7E);                 // PLL half, both pairs, 8 MHz
        idle(2200);
        write_cfg(8'h9F);                 // 2 MHz, wide
        idle(2200);
        write_at_pos(2047, 8'hB4);        // misses this boundary (R9)
        idle(2200);
        write_at_pos(2046, 8'hD3);        // just makes this boundary (R9)
        idle(200);
        fail_a = 1'b1;  fail_b = 1'b1;  idle(100);
        fail_a = 1'b0;  fail_b = 1'b0;
        idle(2200);
        write_cfg(8'hEF);                 // master clock, both pairs
        idle(2200);
        write_cfg(8'h00);                 // everything off again
        idle(2300);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule